// File: doc/BRIEF.md
# Banked Short-Vector Element Sequencer

This block takes one floating-point vector instruction and runs it as a strict loop of single-element operations. It works over a local file of 32 single-word registers, grouped into four banks of eight. The instruction names a starting register for each of two sources and for the destination, and carries an opcode. The element count comes from a length field held outside the instruction: a 3-bit value that encodes the count minus one.

For each element, the sequencer presents the opcode, the three register indices and the two source words to an external arithmetic unit through a valid/ready handshake. It then waits for that unit's result and writes the result into the destination register. After the write, every index moves up by one and wraps within its own bank of eight. An index in bank 0 (registers 0 to 7) marks a scalar operand. If the destination is in bank 0, the instruction runs one element only. If only a source is in bank 0, that source stays fixed for every element.

A host port loads the register file and reads it back while the block is idle.

Top module: `vec_bank_seq`

## Requirements
- R1: After reset, `busy` and `iss_valid` are low, `ins_ready` is high, and every register reads back as zero.
- R2: When the destination index is in banks 1 to 3 (index 8 or above), exactly `cfg_len_m1`+1 elements are issued, from 1 for value 0 up to 8 for value 7, after which the block goes idle with no further element.
- R3: Elements are issued one at a time in ascending order. Element k uses each non-scalar start index plus k, and every element carries the opcode of its instruction.
- R4: An index that steps past the last register of its bank (offset 7, index bits [2:0]) wraps to offset 0 of the same bank, and its bank bits [4:3] never change.
- R5: A destination index in bank 0 (index 0 to 7) makes the operation scalar: exactly one element is issued, whatever the length field holds.
- R6: A source index in bank 0 stays the same for every element while the other indices step.
- R7: A 5-element operation with sources starting at 10 and 18 and the destination starting at 26 reads registers 10 to 14 and 18 to 22 and writes registers 26 to 30.
- R8: `busy` rises in the cycle after an instruction is accepted and falls in the cycle after the last element result is written. While `busy` is high, `ins_ready` is low and an offered instruction is ignored.
- R9: Each element's result is written to its destination register before the next element's source words are presented, so overlapping source and destination ranges behave as a sequential loop.
- R10: While `iss_valid` is high and `iss_ready` is low, `iss_valid` and all issued indices hold steady. Only one element is outstanding at a time.
- R11: A host write takes effect only while the block is idle and no instruction is being accepted. Host writes offered while busy leave the register file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_m1 | input | 3 | Element count minus one, sampled at acceptance |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Instruction can be accepted (idle) |
| ins_op | input | 4 | Opcode passed through to the arithmetic unit |
| ins_src_a | input | 5 | First register of source A |
| ins_src_b | input | 5 | First register of source B |
| ins_dst | input | 5 | First register of the destination |
| iss_valid | output | 1 | Element operation offered to the arithmetic unit |
| iss_ready | input | 1 | Arithmetic unit takes the element |
| iss_op | output | 4 | Opcode of the current element |
| iss_a_idx | output | 5 | Source A register of the current element |
| iss_b_idx | output | 5 | Source B register of the current element |
| iss_d_idx | output | 5 | Destination register of the current element |
| iss_a_data | output | 32 | Contents of source A register |
| iss_b_data | output | 32 | Contents of source B register |
| res_valid | input | 1 | Element result returned |
| res_data | input | 32 | Element result word |
| busy | output | 1 | Instruction in progress |
| host_we | input | 1 | Host register write strobe |
| host_widx | input | 5 | Host write register index |
| host_wdata | input | 32 | Host write data |
| host_ridx | input | 5 | Host read register index |
| host_rdata | output | 32 | Contents of the host read register |

## Verification
The sequencer is driven with the following patterns:
- all-vector runs that stay inside their banks, which separates correct counting from off-by-one lengths;
- runs that cross the end of a bank, which separate a wrap within the bank from a carry into the next bank;
- a scalar destination with a long length field, which shows whether the destination bank overrides the length;
- a scalar source beside stepping operands, which shows whether the fixed index is honoured per operand;
- a destination one register above source A, with a scalar increment, which builds a running chain whose values are right only if each write lands before the next read;
- arithmetic-unit stalls and instructions or host writes offered mid-run, which expose a handshake that moves while stalled and intrusions that should be ignored.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
    localparam int unsigned NUM_REGS  = 32;
    localparam int unsigned BANK_REGS = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned OP_W      = 4;
    localparam int unsigned LEN_W     = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;
endpackage

// File: rtl/vbs_idx_step.sv
// Advances one register index to the next element, wrapping inside its bank.
// Indices in bank 0 are scalar and never move.
module vbs_idx_step #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned OFS_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] nxt
);
    logic [OFS_W-1:0] ofs_inc;

    assign ofs_inc = idx[OFS_W-1:0] + OFS_W'(1);

    always_comb begin
        if (idx[IDX_W-1:OFS_W] == '0) begin
            nxt = idx;
        end else begin
            nxt = {idx[IDX_W-1:OFS_W], ofs_inc};
        end
    end
endmodule

// File: rtl/vbs_regfile.sv
// Plain register storage: one write port, three combinational read ports.
module vbs_regfile #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  rx_idx,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] mem_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign ra_data = mem_q[ra_idx];
    assign rb_data = mem_q[rb_idx];
    assign rx_data = mem_q[rx_idx];
endmodule

// File: rtl/vec_bank_seq.sv
module vec_bank_seq
    import vbs_pkg::*;
#(
    parameter int unsigned NREGS  = vbs_pkg::NUM_REGS,
    parameter int unsigned BREGS  = vbs_pkg::BANK_REGS,
    parameter int unsigned DW     = vbs_pkg::DATA_W,
    parameter int unsigned OPW    = vbs_pkg::OP_W,
    parameter int unsigned LENW   = vbs_pkg::LEN_W,
    localparam int unsigned IDX_W = $clog2(NREGS),
    localparam int unsigned OFS_W = $clog2(BREGS),
    localparam int unsigned N_OPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LENW-1:0]  cfg_len_m1,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [OPW-1:0]   ins_op,
    input  logic [IDX_W-1:0] ins_src_a,
    input  logic [IDX_W-1:0] ins_src_b,
    input  logic [IDX_W-1:0] ins_dst,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [OPW-1:0]   iss_op,
    output logic [IDX_W-1:0] iss_a_idx,
    output logic [IDX_W-1:0] iss_b_idx,
    output logic [IDX_W-1:0] iss_d_idx,
    output logic [DW-1:0]    iss_a_data,
    output logic [DW-1:0]    iss_b_data,
    input  logic             res_valid,
    input  logic [DW-1:0]    res_data,
    output logic             busy,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_widx,
    input  logic [DW-1:0]    host_wdata,
    input  logic [IDX_W-1:0] host_ridx,
    output logic [DW-1:0]    host_rdata
);
    typedef struct packed {
        seq_state_e      state;
        logic [OPW-1:0]  op;
        logic [IDX_W-1:0] a;
        logic [IDX_W-1:0] b;
        logic [IDX_W-1:0] d;
        logic [LENW-1:0] remain;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [DW-1:0]    wr_data;

    // Operand slots: 0 = source A, 1 = source B, 2 = destination
    logic [IDX_W-1:0] cur_idx [N_OPS];
    logic [IDX_W-1:0] nxt_idx [N_OPS];

    assign cur_idx[0] = seq_q.a;
    assign cur_idx[1] = seq_q.b;
    assign cur_idx[2] = seq_q.d;

    for (genvar g = 0; g < N_OPS; g++) begin : g_step
        vbs_idx_step #(
            .IDX_W (IDX_W),
            .OFS_W (OFS_W)
        ) i_step (
            .idx (cur_idx[g]),
            .nxt (nxt_idx[g])
        );
    end

    vbs_regfile #(
        .NUM_REGS (NREGS),
        .DATA_W   (DW)
    ) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .widx    (wr_idx),
        .wdata   (wr_data),
        .ra_idx  (seq_q.a),
        .ra_data (iss_a_data),
        .rb_idx  (seq_q.b),
        .rb_data (iss_b_data),
        .rx_idx  (host_ridx),
        .rx_data (host_rdata)
    );

    always_comb begin
        seq_d   = seq_q;
        wr_en   = 1'b0;
        wr_idx  = seq_q.d;
        wr_data = res_data;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (ins_valid) begin
                    seq_d.state = ST_ISSUE;
                    seq_d.op    = ins_op;
                    seq_d.a     = ins_src_a;
                    seq_d.b     = ins_src_b;
                    seq_d.d     = ins_dst;
                    // scalar destination forces a single element
                    seq_d.remain = (ins_dst[IDX_W-1:OFS_W] == '0) ? '0 : cfg_len_m1;
                end else if (host_we) begin
                    wr_en   = 1'b1;
                    wr_idx  = host_widx;
                    wr_data = host_wdata;
                end
            end
            ST_ISSUE: begin
                if (iss_ready) begin
                    seq_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (res_valid) begin
                    wr_en = 1'b1;
                    if (seq_q.remain == '0) begin
                        seq_d.state = ST_IDLE;
                    end else begin
                        seq_d.state  = ST_ISSUE;
                        seq_d.remain = seq_q.remain - LENW'(1);
                        seq_d.a      = nxt_idx[0];
                        seq_d.b      = nxt_idx[1];
                        seq_d.d      = nxt_idx[2];
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, op: '0, a: '0, b: '0, d: '0, remain: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state != ST_IDLE);
    assign ins_ready = ~busy;
    assign iss_valid = (seq_q.state == ST_ISSUE);
    assign iss_op    = seq_q.op;
    assign iss_a_idx = seq_q.a;
    assign iss_b_idx = seq_q.b;
    assign iss_d_idx = seq_q.d;
endmodule

// File: rtl/vbs_chk.sv
module vbs_chk #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned OFS_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             busy,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [IDX_W-1:0] iss_a_idx,
    input logic [IDX_W-1:0] iss_d_idx,
    input logic             res_valid
);
    logic                   have_prev_q;
    logic [IDX_W-OFS_W-1:0] prev_bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            prev_bank_q <= '0;
        end else if (!busy) begin
            have_prev_q <= 1'b0;
        end else if (iss_valid && iss_ready) begin
            have_prev_q <= 1'b1;
            prev_bank_q <= iss_d_idx[IDX_W-1:OFS_W];
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !iss_valid);

    // R8
    start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ins_valid));

    // R8
    finish_on_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(res_valid));

    // R10
    issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_d_idx) && $stable(iss_a_idx)));

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> !iss_valid);

    // R4
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && have_prev_q) |-> (iss_d_idx[IDX_W-1:OFS_W] == prev_bank_q));
endmodule

bind vec_bank_seq vbs_chk #(
    .IDX_W (IDX_W),
    .OFS_W (OFS_W)
) i_vbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .busy      (busy),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_a_idx (iss_a_idx),
    .iss_d_idx (iss_d_idx),
    .res_valid (res_valid)
);

// File: tb/test_vec_bank_seq.sv
`timescale 1ns/1ps
module test_vec_bank_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_len_m1 = '0;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [3:0]  ins_op = '0;
    logic [4:0]  ins_src_a = '0, ins_src_b = '0, ins_dst = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [3:0]  iss_op;
    logic [4:0]  iss_a_idx, iss_b_idx, iss_d_idx;
    logic [31:0] iss_a_data, iss_b_data;
    logic        res_valid = 1'b0;
    logic [31:0] res_data = '0;
    logic        busy;
    logic        host_we = 1'b0;
    logic [4:0]  host_widx = '0, host_ridx = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] exp_rf [32];

    always #4 clk = ~clk;

    vec_bank_seq i_vec_bank_seq (
        .clk, .rst_n, .cfg_len_m1, .ins_valid, .ins_ready, .ins_op,
        .ins_src_a, .ins_src_b, .ins_dst, .iss_valid, .iss_ready, .iss_op,
        .iss_a_idx, .iss_b_idx, .iss_d_idx, .iss_a_data, .iss_b_data,
        .res_valid, .res_data, .busy, .host_we, .host_widx, .host_wdata,
        .host_ridx, .host_rdata
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int step_idx(input int i);
        if (i < 8) return i;
        return (i & 24) | ((i + 1) & 7);
    endfunction

    task automatic host_write(input int idx, input logic [31:0] val);
        @(negedge clk);
        host_we = 1'b1; host_widx = 5'(idx); host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // Compares the whole register file to the bench model through the host read port.
    task automatic compare_rf(input string req, input string what);
        int bad_idx = -1;
        logic [31:0] bad_val = '0;
        for (int i = 0; i < 32; i++) begin
            host_ridx = 5'(i);
            #1;
            if (host_rdata !== exp_rf[i] && bad_idx < 0) begin
                bad_idx = i; bad_val = host_rdata;
            end
        end
        chk(bad_idx < 0, req, {what, " register file contents"},
            bad_val, (bad_idx < 0) ? 0 : exp_rf[bad_idx]);
    endtask

    // Runs one vector instruction, acting as the arithmetic unit (result = a + b).
    task automatic run_vec(input string req, input int a0, input int b0, input int d0,
                           input int lenm1, input int stall, input bit poke);
        int n = (d0 < 8) ? 1 : lenm1 + 1;
        int ea = a0, eb = b0, ed = d0;
        logic [3:0] op = 4'(a0 + 3);
        @(negedge clk);
        cfg_len_m1 = 3'(lenm1); ins_op = op;
        ins_src_a = 5'(a0); ins_src_b = 5'(b0); ins_dst = 5'(d0);
        ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
        chk(busy === 1'b1, "R8", "busy after accept", busy, 1);
        for (int k = 0; k < n; k++) begin
            for (int w = 0; w < 20 && iss_valid !== 1'b1; w++) @(negedge clk);
            chk(iss_valid === 1'b1, req, "element issued", iss_valid, 1);
            chk(iss_a_idx == 5'(ea), req, "source A index", iss_a_idx, ea);
            chk(iss_b_idx == 5'(eb), req, "source B index", iss_b_idx, eb);
            chk(iss_d_idx == 5'(ed), req, "dest index", iss_d_idx, ed);
            chk(iss_op == op, "R3", "opcode", iss_op, op);
            // R9: operands must reflect every earlier element's write
            chk(iss_a_data == exp_rf[ea], "R9", "source A word", iss_a_data, exp_rf[ea]);
            chk(iss_b_data == exp_rf[eb], "R9", "source B word", iss_b_data, exp_rf[eb]);
            if (poke && k == 0) begin
                ins_valid = 1'b1; ins_src_a = 5'd1; ins_src_b = 5'd2; ins_dst = 5'd3;
                chk(ins_ready === 1'b0, "R8", "ready while busy", ins_ready, 0);
            end
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(iss_valid === 1'b1 && iss_d_idx == 5'(ed) && iss_a_idx == 5'(ea),
                    "R10", "held under stall", iss_d_idx, ed);
            end
            iss_ready = 1'b1;
            @(negedge clk);
            iss_ready = 1'b0;
            ins_valid = 1'b0;
            @(negedge clk);
            res_valid = 1'b1;
            res_data = exp_rf[ea] + exp_rf[eb];
            if (poke) begin
                host_we = 1'b1; host_widx = 5'd5; host_wdata = 32'hDEAD_0000;
            end
            @(negedge clk);
            res_valid = 1'b0;
            host_we = 1'b0;
            exp_rf[ed] = exp_rf[ea] + exp_rf[eb];
            ea = step_idx(ea); eb = step_idx(eb); ed = step_idx(ed);
        end
        chk(busy === 1'b0, "R8", "busy after last write", busy, 0);
        @(negedge clk);
        chk(iss_valid === 1'b0 && busy === 1'b0, req, "no extra element", iss_valid, 0);
        compare_rf(req, "after run");
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R1", "busy at reset", busy, 0);
        chk(iss_valid === 1'b0, "R1", "iss_valid at reset", iss_valid, 0);
        chk(ins_ready === 1'b1, "R1", "ins_ready at reset", ins_ready, 1);
        for (int i = 0; i < 32; i++) exp_rf[i] = '0;
        compare_rf("R1", "reset");
    endtask

    task automatic t_load;
        for (int i = 0; i < 32; i++) begin
            exp_rf[i] = 32'(i * 3 + 1);
            host_write(i, exp_rf[i]);
        end
        compare_rf("R11", "host load");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        run_vec("R7", 10, 18, 26, 4, 0, 1'b0);      // worked example
        run_vec("R4", 14, 20, 29, 3, 0, 1'b0);      // wrap inside bank
        run_vec("R5", 9, 17, 3, 6, 0, 1'b0);        // scalar destination
        run_vec("R6", 2, 17, 25, 2, 0, 1'b0);       // scalar source A
        run_vec("R2", 16, 8, 24, 7, 0, 1'b0);       // full 8 elements
        run_vec("R2", 12, 21, 30, 0, 0, 1'b0);      // length 1
        host_write(1, 32'd1); exp_rf[1] = 32'd1;
        run_vec("R9", 9, 1, 10, 4, 0, 1'b0);        // overlapping chain
        run_vec("R10", 11, 19, 27, 2, 3, 1'b0);     // arithmetic stalls
        run_vec("R11", 13, 22, 31, 2, 1, 1'b1);     // intrusions while busy
        run_vec("R3", 8, 16, 24, 5, 0, 1'b0);       // plain ascending
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule